// File: doc/BRIEF.md
# Bit Matrix Transpose Unit

This block takes a 64-bit operand and reads it as a square grid of bits. Each of the eight bytes is one row of eight bits. The block returns the transpose of that grid. Bit positions are counted from the most significant end, so position 0 is the top bit of the word.

The output can be taken straight from the wiring. It can also come from a register that adds one cycle of latency. The register is chosen by a parameter. A one-bit valid input goes with the operand, and a matching valid output goes with the result. The operand bus is only read, never driven, so the caller's copy of the operand stays unchanged. Only the result carries the transposed value.

Top module: `bit_matrix_transpose`

## Requirements
- R1: Bit positions are counted from the MSB, so position p is LSB index 63-p. The source bit at row r, column c (position r*8+c) appears in the result at position c*8+r.
- R2: Position 0 stays at position 0. Position 1 (LSB index 62) moves to position 8 (LSB index 55). Position 7 (LSB index 56) moves to position 56 (LSB index 7).
- R3: The eight diagonal bits (positions r*8+r) hold the same value in the result as in the source.
- R4: Applying the transpose twice gives back the original operand. Feeding a result back in as the source returns the earlier source.
- R5: With the output register enabled (the default), out_valid equals in_valid one clock later. The result for an operand presented with in_valid high appears on the next cycle.
- R6: While rst_n is low, out_valid and result are both 0.
- R7: In a cycle where in_valid is low, the registered result keeps its previous value, whatever the source holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source operand is valid this cycle |
| src | input | 64 | Source operand, bit 63 is matrix position 0 |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Transposed operand |

## Verification
The transpose is pure wiring, so a single swapped or mis-numbered wire shows up at once. It corrupts the result in the same cycle the affected source bit is set. Sparse single-bit operands therefore locate the fault exactly. A fault in the output register shows within one cycle, in one of two ways. A wrong load enable overwrites a held value on an idle cycle. A broken valid path shifts out_valid against the data it should mark. Running the result back through the unit catches any mapping that is not its own inverse.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  localparam int MAT_DIM = 8;
  localparam int WORD_W  = MAT_DIM * MAT_DIM;

  // MSB-first position p -> LSB index
  function automatic int lsb_idx(input int p);
    return WORD_W - 1 - p;
  endfunction

  function automatic logic [WORD_W-1:0] xpose_word(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] o;
    o = '0;
    for (int r = 0; r < MAT_DIM; r++)
      for (int c = 0; c < MAT_DIM; c++)
        o[lsb_idx(c*MAT_DIM + r)] = w[lsb_idx(r*MAT_DIM + c)];
    return o;
  endfunction

  function automatic logic [WORD_W-1:0] diag_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int d = 0; d < MAT_DIM; d++) m[lsb_idx(d*MAT_DIM + d)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/bmt_xpose_core.sv
module bmt_xpose_core #(
  parameter int DIM = bmt_pkg::MAT_DIM,
  localparam int W  = DIM * DIM
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign dout[W-1-(c*DIM+r)] = din[W-1-(r*DIM+c)];
    end
  end

  // diagonal positions, computed for the check below
  logic [W-1:0] diag_m;
  always_comb begin
    diag_m = '0;
    for (int d = 0; d < DIM; d++) diag_m[W-1-(d*DIM+d)] = 1'b1;
  end

  logic diag_kept;
  assign diag_kept = (((din ^ dout) & diag_m) == '0);

  always_comb begin
    if (!$isunknown(din)) begin
      // R3
      diag_fixed_chk: assert (diag_kept);
    end
  end
endmodule

// File: rtl/bmt_out_stage.sv
module bmt_out_stage #(
  parameter int W       = bmt_pkg::WORD_W,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [W-1:0] d_in,
  output logic         v_out,
  output logic [W-1:0] d_out
);
  if (REG_OUT) begin : g_reg
    logic         v_q;
    logic [W-1:0] d_q;
    logic         load_en;
    assign load_en = v_in;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= v_in;
        if (load_en) d_q <= d_in;
      end
    end
    assign v_out = v_q;
    assign d_out = d_q;

    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (v_out == $past(v_in)));
    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(v_in)) |-> $stable(d_out));
    // R6
    always_comb begin
      if (rst_n === 1'b0) begin
        reset_clear_chk: assert (v_q == 1'b0 && d_q == '0);
      end
    end
  end else begin : g_comb
    assign v_out = v_in;
    assign d_out = d_in;
  end
endmodule

// File: rtl/bit_matrix_transpose.sv
module bit_matrix_transpose #(
  parameter bit REG_OUT = 1'b1,
  localparam int W      = bmt_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] src,
  output logic         out_valid,
  output logic [W-1:0] result
);
  logic [W-1:0] xposed;

  bmt_xpose_core #(.DIM(bmt_pkg::MAT_DIM)) u_core (
    .din  (src),
    .dout (xposed)
  );

  bmt_out_stage #(.W(W), .REG_OUT(REG_OUT)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .v_in  (in_valid),
    .d_in  (xposed),
    .v_out (out_valid),
    .d_out (result)
  );

  if (REG_OUT) begin : g_chk
    // R4
    involution_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid) |-> (bmt_pkg::xpose_word(result) == $past(src)));
    // R1
    mapping_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && out_valid) |->
        (result[bmt_pkg::lsb_idx(1)] == $past(src[bmt_pkg::lsb_idx(8)])));
  end
endmodule

// File: tb/bit_matrix_transpose_test.sv
module bit_matrix_transpose_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] src;
  logic        out_valid;
  logic [63:0] result;

  int checks = 0;
  int errors = 0;
  logic [63:0] held = '0;
  logic [63:0] rng  = 64'h9231_5897_2083_ffff;

  bit_matrix_transpose uut (.*);

  always #5 clk = ~clk;

  // reference: row r column c, MSB-first numbering
  function automatic logic [63:0] ref_t(input logic [63:0] a);
    logic [63:0] o = '0;
    for (int row = 0; row < 8; row++)
      for (int col = 0; col < 8; col++)
        if (a[63 - (row*8 + col)]) o[63 - (col*8 + row)] = 1'b1;
    return o;
  endfunction

  function automatic logic [63:0] next_rng(input logic [63:0] x);
    logic [63:0] y = x;
    y ^= y << 13; y ^= y >> 7; y ^= y << 17;
    return y;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, check after the following posedge
  task automatic step(input logic v, input logic [63:0] d, input string req);
    in_valid = v; src = d;
    @(posedge clk); @(negedge clk);
    chk({req, " valid (R5)"}, {63'd0, out_valid}, {63'd0, v});
    if (v) held = ref_t(d);
    chk({req, v ? " data" : " hold (R7)"}, result, held);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src = '1;
    repeat (3) @(negedge clk);
    chk("R6 valid in reset", {63'd0, out_valid}, 64'd0);
    chk("R6 result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 single-bit numbering
    step(1'b1, 64'h8000_0000_0000_0000, "R2 pos0");
    step(1'b1, 64'h4000_0000_0000_0000, "R2 pos1");
    chk("R2 pos1->pos8", result, 64'h0080_0000_0000_0000);
    step(1'b1, 64'h0100_0000_0000_0000, "R2 pos7");
    chk("R2 pos7->pos56", result, 64'h0000_0000_0000_0080);
    // R1 every single bit
    for (int p = 0; p < 64; p++) step(1'b1, 64'd1 << (63 - p), "R1 walk");
    step(1'b1, 64'h9231_5897_2083_ffff, "R1 pattern");
    step(1'b1, 64'hFF00_FF00_FF00_FF00, "R1 rows");
    chk("R1 rows->cols", result, 64'hAAAA_AAAA_AAAA_AAAA);
    // R7 hold with garbage source
    step(1'b0, 64'h1234_5678_9ABC_DEF0, "R7 idle a");
    step(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R7 idle b");
    // random traffic, R3 and R4
    for (int i = 0; i < 300; i++) begin
      logic [63:0] d;
      rng = next_rng(rng); d = rng;
      rng = next_rng(rng);
      step(rng[5:4] != 2'b00, d, "R1 random");
      if (rng[5:4] != 2'b00) begin
        chk("R3 diagonal", result & 64'h8040_2010_0804_0201, d & 64'h8040_2010_0804_0201);
        step(1'b1, result, "R4 feed back");
        chk("R4 twice", result, d);
      end
    end
    step(1'b0, '0, "R5 tail");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule